// File: doc/BRIEF.md
# Relative Branch Target Decoder

This block resolves the control-flow instructions of a 16-bit microcontroller core. Given the address of the current instruction, its first three bytes and the operand values the execute stage has already fetched (a condition-met flag, a byte register for bit tests and a loop counter), it works out whether the branch is taken. It then gives the address of the next instruction, the instruction length and the number of state times the instruction costs. For the loop-counter forms it also gives the decremented counter and a write strobe.

Instructions enter on a valid/ready stream and the results leave one cycle later on a second valid/ready stream, through a single register stage. Back-pressure rule: `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds its value and no new instruction is accepted. A transfer happens on a rising edge where valid and ready are both high.

All address arithmetic is modulo 2^16. Every displacement is sign-extended and added to the address of the byte after the instruction.

Top module: `branch_target_decoder`

## Requirements
- R1: Opcode 0xE7 is a 3-byte long jump. Its displacement is the 16-bit value {byte2, byte1}, with the low byte in byte1. next_ip = ip + 3 + displacement, taken = 1, cost 8 states.
- R2: Opcodes 0x20 to 0x27 (bit pattern 00100xxx) are a 2-byte short jump. Its displacement is the 11-bit signed value {opcode[2:0], byte1}. next_ip = ip + 2 + displacement, taken = 1, cost 8 states. For example, 0x27 0xFE at 0x8220 targets 0x8220.
- R3: Opcodes 0xD0 to 0xDF are 2-byte conditional jumps with a signed 8-bit displacement in byte1, decided by `in_cond`. When taken: ip + 2 + displacement and 8 states. When not taken: ip + 2 and 4 states.
- R4: Opcodes 00111bbb (jump if bit set) and 00110bbb (jump if bit clear) are 3 bytes long. They test bit bbb of `in_bitreg` and take a signed 8-bit displacement from byte2. When taken: ip + 3 + displacement and 9 states. When not taken: ip + 3 and 5 states.
- R5: Opcode 0xE0 is the 3-byte byte-counter loop. out_count = {in_count[15:8], in_count[7:0] - 1}, with the low byte wrapping from 0x00 to 0xFF, and out_count_we = 1. The branch is taken when the new low byte is nonzero, using the displacement in byte2. Cost is 9 states taken and 5 not taken.
- R6: Opcode 0xE1 is the 3-byte word-counter loop. out_count = in_count - 1 and out_count_we = 1. The branch is taken when the result is nonzero. Cost is 10 states taken and 5 not taken. A counter that starts at 0xF000 and is fed back each time is taken 61439 times and falls through on pass 61440.
- R7: For every opcode other than 0xE0 and 0xE1, out_count_we = 0 and out_count equals in_count. `in_cond` affects only the conditional group, and `in_bitreg` affects only the bit-test group.
- R8: Target arithmetic wraps modulo 2^16 in both directions.
- R9: Any other opcode sets out_illegal = 1, with next_ip = ip + 1, length 1, taken = 0, cost 0 and no counter write.
- R10: One register stage sits between the input and output streams, with in_ready = !out_valid || out_ready. The outputs hold while they are stalled, and an accepted instruction appears at the output on the next cycle.
- R11: While reset is applied and after it is released, out_valid = 0 until an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can accept |
| in_ip | input | 16 | Address of the instruction |
| in_op0 | input | 8 | Opcode byte |
| in_op1 | input | 8 | Second instruction byte |
| in_op2 | input | 8 | Third instruction byte |
| in_cond | input | 1 | Condition met, for the conditional group |
| in_bitreg | input | 8 | Byte register tested by the bit-test forms |
| in_count | input | 16 | Loop counter register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer can take the result |
| out_next_ip | output | 16 | Address of the next instruction |
| out_len | output | 2 | Instruction length in bytes |
| out_states | output | 4 | State-time cost |
| out_taken | output | 1 | Branch taken |
| out_count | output | 16 | Updated counter value |
| out_count_we | output | 1 | Counter write strobe |
| out_illegal | output | 1 | Opcode not in the branch set |

## Verification
The main function is tried with forward and backward displacements at each length. These include the most negative long and short offsets, which separate a correct sign extension from a zero extension and a correct wrap from a saturating adder. Each taken and not-taken pair is run with the same operands, so that the cost and target of the two paths are told apart. Bit tests use bits 0, 3, 5 and 7 with the tested bit both set and clear. Counter cases cover 1 down to 0, 0 wrapping to all ones, and the full 0xF000 loop fed back through the outputs. Stalls and unrelated operand values are checked to show that they leave the results unchanged.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int COST_W  = 4;
  localparam int LEN_W   = 2;

  localparam logic [7:0] OPC_LONG   = 8'hE7;
  localparam logic [7:0] OPC_LOOPB  = 8'hE0;
  localparam logic [7:0] OPC_LOOPW  = 8'hE1;
  localparam logic [4:0] PFX_SHORT  = 5'b00100;
  localparam logic [4:0] PFX_BITSET = 5'b00111;
  localparam logic [4:0] PFX_BITCLR = 5'b00110;
  localparam logic [3:0] PFX_COND   = 4'hD;

  localparam logic [COST_W-1:0] COST_JMP     = 4'd8;
  localparam logic [COST_W-1:0] COST_COND_NT = 4'd4;
  localparam logic [COST_W-1:0] COST_COND_T  = 4'd8;
  localparam logic [COST_W-1:0] COST_3B_NT   = 4'd5;
  localparam logic [COST_W-1:0] COST_3B_T    = 4'd9;
  localparam logic [COST_W-1:0] COST_LOOPW_T = 4'd10;

  typedef enum logic [2:0] {
    K_ILL, K_LONG, K_SHORT, K_COND, K_BITSET, K_BITCLR, K_LOOPB, K_LOOPW
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] disp;
    logic [COST_W-1:0] cost_nt;
    logic [COST_W-1:0] cost_t;
    logic [2:0]        bitsel;
  } dec_t;

  typedef struct packed {
    logic [ADDR_W-1:0] next_ip;
    logic [LEN_W-1:0]  len;
    logic [COST_W-1:0] cost;
    logic              taken;
    logic [ADDR_W-1:0] count;
    logic              count_we;
    logic              illegal;
  } res_t;
endpackage

// File: rtl/bt_opcode_decode.sv
module bt_opcode_decode
  import bt_pkg::*;
(
  input  logic [BYTE_W-1:0] op0,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  output dec_t              dec
);
  localparam int SHORT_W = BYTE_W + 3;

  logic [ADDR_W-1:0] disp8_b1;
  logic [ADDR_W-1:0] disp8_b2;
  logic [ADDR_W-1:0] disp11;
  logic [SHORT_W-1:0] short_raw;

  assign short_raw = {op0[2:0], op1};
  assign disp8_b1  = {{(ADDR_W-BYTE_W){op1[BYTE_W-1]}}, op1};
  assign disp8_b2  = {{(ADDR_W-BYTE_W){op2[BYTE_W-1]}}, op2};
  assign disp11    = {{(ADDR_W-SHORT_W){short_raw[SHORT_W-1]}}, short_raw};

  always_comb begin
    dec.kind    = K_ILL;
    dec.len     = 2'd1;
    dec.disp    = '0;
    dec.cost_nt = '0;
    dec.cost_t  = '0;
    dec.bitsel  = op0[2:0];
    if (op0 == OPC_LONG) begin
      dec.kind    = K_LONG;
      dec.len     = 2'd3;
      dec.disp    = {op2, op1};
      dec.cost_nt = COST_JMP;
      dec.cost_t  = COST_JMP;
    end else if (op0 == OPC_LOOPB || op0 == OPC_LOOPW) begin
      dec.kind    = (op0 == OPC_LOOPB) ? K_LOOPB : K_LOOPW;
      dec.len     = 2'd3;
      dec.disp    = disp8_b2;
      dec.cost_nt = COST_3B_NT;
      dec.cost_t  = (op0 == OPC_LOOPB) ? COST_3B_T : COST_LOOPW_T;
    end else if (op0[7:3] == PFX_SHORT) begin
      dec.kind    = K_SHORT;
      dec.len     = 2'd2;
      dec.disp    = disp11;
      dec.cost_nt = COST_JMP;
      dec.cost_t  = COST_JMP;
    end else if (op0[7:4] == PFX_COND) begin
      dec.kind    = K_COND;
      dec.len     = 2'd2;
      dec.disp    = disp8_b1;
      dec.cost_nt = COST_COND_NT;
      dec.cost_t  = COST_COND_T;
    end else if (op0[7:3] == PFX_BITSET || op0[7:3] == PFX_BITCLR) begin
      dec.kind    = (op0[7:3] == PFX_BITSET) ? K_BITSET : K_BITCLR;
      dec.len     = 2'd3;
      dec.disp    = disp8_b2;
      dec.cost_nt = COST_3B_NT;
      dec.cost_t  = COST_3B_T;
    end
  end
endmodule

// File: rtl/bt_take_eval.sv
module bt_take_eval
  import bt_pkg::*;
(
  input  dec_t              dec,
  input  logic              cond,
  input  logic [BYTE_W-1:0] bitreg,
  input  logic [ADDR_W-1:0] count_in,
  output logic              taken,
  output logic [COST_W-1:0] cost,
  output logic [ADDR_W-1:0] count_out,
  output logic              count_we
);
  logic [BYTE_W-1:0] low_dec;
  logic [ADDR_W-1:0] word_dec;

  assign low_dec  = count_in[BYTE_W-1:0] - 1'b1;
  assign word_dec = count_in - 1'b1;

  always_comb begin
    taken     = 1'b0;
    count_out = count_in;
    count_we  = 1'b0;
    unique case (dec.kind)
      K_LONG, K_SHORT: taken = 1'b1;
      K_COND:          taken = cond;
      K_BITSET:        taken = bitreg[dec.bitsel];
      K_BITCLR:        taken = ~bitreg[dec.bitsel];
      K_LOOPB: begin
        count_out = {count_in[ADDR_W-1:BYTE_W], low_dec};
        count_we  = 1'b1;
        taken     = |low_dec;
      end
      K_LOOPW: begin
        count_out = word_dec;
        count_we  = 1'b1;
        taken     = |word_dec;
      end
      default: taken = 1'b0;
    endcase
    cost = taken ? dec.cost_t : dec.cost_nt;
  end
endmodule

// File: rtl/bt_target_calc.sv
module bt_target_calc
  import bt_pkg::*;
(
  input  logic [ADDR_W-1:0] ip,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] disp,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_ip
);
  logic [ADDR_W-1:0] fall_ip;

  assign fall_ip = ip + ADDR_W'(len);
  assign next_ip = taken ? (fall_ip + disp) : fall_ip;
endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_target_decoder.sv
module branch_target_decoder
  import bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_ip,
  input  logic [7:0]  in_op0,
  input  logic [7:0]  in_op1,
  input  logic [7:0]  in_op2,
  input  logic        in_cond,
  input  logic [7:0]  in_bitreg,
  input  logic [15:0] in_count,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_next_ip,
  output logic [1:0]  out_len,
  output logic [3:0]  out_states,
  output logic        out_taken,
  output logic [15:0] out_count,
  output logic        out_count_we,
  output logic        out_illegal
);
  localparam int RES_W = $bits(res_t);

  dec_t              dec;
  logic              taken;
  logic [COST_W-1:0] cost;
  logic [ADDR_W-1:0] cnt_next;
  logic              cnt_we;
  logic [ADDR_W-1:0] next_ip;
  res_t              res_in;
  res_t              res_out;
  logic [RES_W-1:0]  res_q;

  bt_opcode_decode u_dec (
    .op0(in_op0), .op1(in_op1), .op2(in_op2), .dec(dec)
  );

  bt_take_eval u_eval (
    .dec(dec), .cond(in_cond), .bitreg(in_bitreg), .count_in(in_count),
    .taken(taken), .cost(cost), .count_out(cnt_next), .count_we(cnt_we)
  );

  bt_target_calc u_tgt (
    .ip(in_ip), .len(dec.len), .disp(dec.disp), .taken(taken),
    .next_ip(next_ip)
  );

  always_comb begin
    res_in.next_ip  = next_ip;
    res_in.len      = dec.len;
    res_in.cost     = cost;
    res_in.taken    = taken;
    res_in.count    = cnt_next;
    res_in.count_we = cnt_we;
    res_in.illegal  = (dec.kind == K_ILL);
  end

  bt_out_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign res_out      = res_t'(res_q);
  assign out_next_ip  = res_out.next_ip;
  assign out_len      = res_out.len;
  assign out_states   = res_out.cost;
  assign out_taken    = res_out.taken;
  assign out_count    = res_out.count;
  assign out_count_we = res_out.count_we;
  assign out_illegal  = res_out.illegal;
endmodule

// File: rtl/branch_target_decoder_checker.sv
module branch_target_decoder_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_next_ip,
  input logic [1:0]  out_len,
  input logic [3:0]  out_states,
  input logic        out_taken,
  input logic        out_count_we,
  input logic        out_illegal
);
  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_ip)
      && $stable(out_states) && $stable(out_len));

  assert_illegal_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_len == 2'd1 && !out_taken
      && out_states == 4'd0 && !out_count_we);

  assert_not_taken_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && !out_taken |->
      (out_states == 4'd4 || out_states == 4'd5));

  assert_taken_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_states >= 4'd8 && !out_illegal);

  assert_counter_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_count_we |-> out_len == 2'd3 && !out_illegal);
endmodule

bind branch_target_decoder branch_target_decoder_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_next_ip(out_next_ip),
  .out_len(out_len), .out_states(out_states), .out_taken(out_taken),
  .out_count_we(out_count_we), .out_illegal(out_illegal)
);

// File: tb/branch_target_decoder_test.sv
module branch_target_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_ip = '0;
  logic [7:0]  in_op0 = '0, in_op1 = '0, in_op2 = '0;
  logic        in_cond = 1'b0;
  logic [7:0]  in_bitreg = '0;
  logic [15:0] in_count = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_next_ip;
  logic [1:0]  out_len;
  logic [3:0]  out_states;
  logic        out_taken;
  logic [15:0] out_count;
  logic        out_count_we;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  branch_target_decoder uut (.*);

  typedef struct packed {
    logic [15:0] ip;
    logic [7:0]  op0, op1, op2;
    logic        cond;
    logic [7:0]  bits;
    logic [15:0] cnt;
    logic [15:0] nip;
    logic [1:0]  len;
    logic [3:0]  st;
    logic        tk;
    logic [15:0] ocnt;
    logic        we;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{16'h800C, 8'hE7, 8'h9D, 8'h02, 1'b0, 8'h00, 16'h0000, 16'h82AC, 2'd3, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd1}, // R1
    '{16'h1000, 8'hE7, 8'h00, 8'h80, 1'b0, 8'h00, 16'h0000, 16'h9003, 2'd3, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd8}, // R8
    '{16'h8220, 8'h27, 8'hFE, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h8220, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd2}, // R2
    '{16'h8328, 8'h20, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h832A, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd2}, // R2
    '{16'h0010, 8'h23, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h0312, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd2}, // R2
    '{16'h0100, 8'h24, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 16'hFD02, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd8}, // R8
    '{16'h4000, 8'hD7, 8'h10, 8'h00, 1'b1, 8'h00, 16'h0000, 16'h4012, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd3}, // R3
    '{16'h4000, 8'hD7, 8'h10, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h4002, 2'd2, 4'd4,  1'b0, 16'h0000, 1'b0, 1'b0, 8'd3}, // R3
    '{16'h4000, 8'hDF, 8'h80, 8'h00, 1'b1, 8'h00, 16'h0000, 16'h3F82, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd3}, // R3
    '{16'h2000, 8'h3B, 8'h00, 8'h20, 1'b0, 8'h08, 16'h0000, 16'h2023, 2'd3, 4'd9,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd4}, // R4
    '{16'h2000, 8'h3B, 8'h00, 8'h20, 1'b0, 8'hF7, 16'h0000, 16'h2003, 2'd3, 4'd5,  1'b0, 16'h0000, 1'b0, 1'b0, 8'd4}, // R4
    '{16'h2000, 8'h35, 8'h00, 8'hFE, 1'b0, 8'hDF, 16'h0000, 16'h2001, 2'd3, 4'd9,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd4}, // R4
    '{16'h2000, 8'h30, 8'h00, 8'hFE, 1'b0, 8'h01, 16'h0000, 16'h2003, 2'd3, 4'd5,  1'b0, 16'h0000, 1'b0, 1'b0, 8'd4}, // R4
    '{16'h0000, 8'h3F, 8'h00, 8'h7F, 1'b0, 8'h80, 16'h0000, 16'h0082, 2'd3, 4'd9,  1'b1, 16'h0000, 1'b0, 1'b0, 8'd4}, // R4
    '{16'h3000, 8'hE0, 8'h00, 8'hF0, 1'b0, 8'h00, 16'hAB02, 16'h2FF3, 2'd3, 4'd9,  1'b1, 16'hAB01, 1'b1, 1'b0, 8'd5}, // R5
    '{16'h3000, 8'hE0, 8'h00, 8'hF0, 1'b0, 8'h00, 16'h1201, 16'h3003, 2'd3, 4'd5,  1'b0, 16'h1200, 1'b1, 1'b0, 8'd5}, // R5
    '{16'h3000, 8'hE0, 8'h00, 8'hF0, 1'b0, 8'h00, 16'h5500, 16'h2FF3, 2'd3, 4'd9,  1'b1, 16'h55FF, 1'b1, 1'b0, 8'd5}, // R5
    '{16'h3000, 8'hE1, 8'h00, 8'hF0, 1'b0, 8'h00, 16'h0001, 16'h3003, 2'd3, 4'd5,  1'b0, 16'h0000, 1'b1, 1'b0, 8'd6}, // R6
    '{16'h3000, 8'hE1, 8'h00, 8'hF0, 1'b0, 8'h00, 16'h0000, 16'h2FF3, 2'd3, 4'd10, 1'b1, 16'hFFFF, 1'b1, 1'b0, 8'd6}, // R6
    '{16'h800C, 8'hE7, 8'h9D, 8'h02, 1'b1, 8'hFF, 16'hFFFF, 16'h82AC, 2'd3, 4'd8,  1'b1, 16'hFFFF, 1'b0, 1'b0, 8'd7}, // R7
    '{16'h4000, 8'hD7, 8'h10, 8'h00, 1'b0, 8'hFF, 16'h1234, 16'h4002, 2'd2, 4'd4,  1'b0, 16'h1234, 1'b0, 1'b0, 8'd7}, // R7
    '{16'h5000, 8'hFD, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h5001, 2'd1, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd9}, // R9
    '{16'hFFFF, 8'h28, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h0000, 2'd1, 4'd0,  1'b0, 16'h0000, 1'b0, 1'b1, 8'd9}  // R9
  };

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid  = 1'b1;
    in_ip     = v.ip;
    in_op0    = v.op0;
    in_op1    = v.op1;
    in_op2    = v.op2;
    in_cond   = v.cond;
    in_bitreg = v.bits;
    in_count  = v.cnt;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    int iters;
    // R11: idle while reset is applied and after release
    repeat (3) @(negedge clk);
    check("out_valid in reset", 11, out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("out_valid after reset", 11, out_valid, 0);
    check("in_ready after reset", 11, in_ready, 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("v%0d valid", i), VECS[i].req, out_valid, 1);
      check($sformatf("v%0d next_ip", i), VECS[i].req, out_next_ip, VECS[i].nip);
      check($sformatf("v%0d len", i), VECS[i].req, out_len, VECS[i].len);
      check($sformatf("v%0d states", i), VECS[i].req, out_states, VECS[i].st);
      check($sformatf("v%0d taken", i), VECS[i].req, out_taken, VECS[i].tk);
      check($sformatf("v%0d count", i), VECS[i].req, out_count, VECS[i].ocnt);
      check($sformatf("v%0d count_we", i), VECS[i].req, out_count_we, VECS[i].we);
      check($sformatf("v%0d illegal", i), VECS[i].req, out_illegal, VECS[i].ill);
    end
    @(negedge clk);
    check("drain", 10, out_valid, 0);

    // R10: back-pressure holds the result and blocks the input
    out_ready = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    check("stall valid", 10, out_valid, 1);
    check("stall in_ready", 10, in_ready, 0);
    check("stall first ip", 10, out_next_ip, 16'h82AC);
    drive(VECS[6]);
    @(negedge clk);
    check("stall hold ip", 10, out_next_ip, 16'h82AC);
    check("stall hold states", 10, out_states, 4'd8);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("release next ip", 10, out_next_ip, 16'h4012);
    @(negedge clk);
    check("release drained", 10, out_valid, 0);

    // R6: word counter from 0xF000 fed back through the outputs
    drive(VECS[18]);
    in_count = 16'hF000;
    iters = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      iters++;
      if (!out_taken) break;
      in_count = out_count;
    end
    in_valid = 1'b0;
    check("loop passes", 6, iters, 61440);
    check("loop final count", 6, out_count, 16'h0000);
    check("loop fall-through ip", 6, out_next_ip, 16'h3003);

    @(negedge clk);
    finish_run();
  end
endmodule